// File: doc/BRIEF.md
# Byte-Lane Write Control Decoder

This block sits between an address sequencer and a word-wide storage array split into byte lanes. At every rising clock edge it decides whether the current cycle is a write or a read, and for a write it picks which byte lanes of the addressed word are updated. The decision uses these inputs:

- a global write,
- a byte-write enable,
- one select per lane.

All three are active low. The sequencer reports the kind of cycle on three inputs: a processor-strobe start, a controller-strobe start, or a cycle inside an ongoing burst (continue or suspend). On a burst cycle the address input carries the sequencer's held address.

The block also holds the array and a flow-through read path. Read data comes straight from the array at the address registered on the last edge, without an output register. The block drives an enable for the bidirectional data driver. That enable combines an output-enable input, which acts without the clock, with the block's own knowledge of whether the cycle is a read. A write detected on the current inputs always turns the driver off.

Top module: `blw_write_ctrl`

## Requirements
- R1: On a write-capable cycle with the global write input low (0), all lanes are strobed, whatever the byte-write enable and lane selects are.
- R2: With the global write input high, lane i is strobed only when the byte-write enable is low and select bit i is low. Lane i covers data bits [8i+7:8i], so bit 0 covers 7:0 and bit 3 covers 31:24.
- R3: On a cycle with the processor-strobe start high, no lane is strobed whatever the write inputs are, and the cycle is registered as a read.
- R4: On a cycle with the controller-strobe start high and the processor-strobe start low, the write happens on that same edge if the write inputs ask for one. If the processor-strobe start is also high, the controller start has no effect.
- R5: On a burst cycle (burst input high, both starts low) that asks for a write, the write goes to the address on the address input.
- R6: While the current inputs make a write, the driver enable is low even with the output enable low.
- R7: With the output enable high (1), the driver enable is low at once. With it low after a registered read, the driver enable is high and the read data equals the word at the address registered at the last edge.
- R8: After an edge at which all three cycle inputs were low, the driver enable is low and no lane is strobed, even when the write inputs are active.
- R9: A read of a written address on the following cycle returns the new bytes in the lanes that were written and the old bytes in the others.
- R10: During reset and on the first idle cycle after it, the driver enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_start | input | 1 | Processor-strobe start of an access this cycle |
| ctl_start | input | 1 | Controller-strobe start of an access this cycle |
| in_burst | input | 1 | Continue or suspend cycle of an ongoing burst |
| addr | input | ADDR_W (6) | Word address from the sequencer |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES (4) | Per-lane byte selects, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| wr_data | input | 32 | Data from the pins, captured on the write edge |
| rd_data | output | 32 | Flow-through read data |
| drv_en | output | 1 | Enable for the data pin driver |
| lane_we | output | LANES (4) | Per-lane write strobes for the coming edge |

## Verification
The assertions take two things for granted. First, the sequencer raises at most one meaningful cycle kind, although both starts high together is allowed and resolves to a processor start. Second, all control inputs are stable around the rising edge. The stimulus keeps to this by changing every input on the falling edge only. It sweeps all global-write, byte-enable and select values under each cycle kind, including both starts high at once. Every address is written in full before the first read, so no read ever returns an uninitialised word.

// File: rtl/blw_pkg.sv
package blw_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_e;
endpackage

// File: rtl/blw_cycle_classify.sv
module blw_cycle_classify
    import blw_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             cpu_start,
    input  logic             ctl_start,
    input  logic             in_burst,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    output cyc_kind_e        kind,
    output logic [LANES-1:0] lane_we
);
    logic             write_ok;
    logic             active;
    logic [LANES-1:0] mask;

    // a processor start forbids writing and masks the controller start
    assign write_ok = !cpu_start && (ctl_start || in_burst);
    assign active   = cpu_start || ctl_start || in_burst;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i] = !gw_n || (!bwe_n && !bsel_n[i]);
    end

    always_comb begin
        kind    = CYC_IDLE;
        lane_we = '0;
        if (active) begin
            if (write_ok && (|mask)) begin
                kind    = CYC_WRITE;
                lane_we = mask;
            end else begin
                kind = CYC_READ;
            end
        end
    end

    always_comb begin
        AST_CPU_NO_STROBE: assert (!cpu_start || lane_we == '0); // R3
    end
endmodule

// File: rtl/blw_lane_store.sv
module blw_lane_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        we,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar i = 0; i < LANES; i++) begin : g_bank
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we[i]) begin
                mem_q[wr_addr] <= wdata[i*LANE_W +: LANE_W];
            end
        end

        assign rdata[i*LANE_W +: LANE_W] = mem_q[rd_addr];
    end
endmodule

// File: rtl/blw_write_ctrl.sv
module blw_write_ctrl
    import blw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_start,
    input  logic              ctl_start,
    input  logic              in_burst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bsel_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              drv_en,
    output logic [LANES-1:0]  lane_we
);
    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } state_t;

    state_t    st_d, st_q;
    cyc_kind_e kind;

    blw_cycle_classify #(.LANES(LANES)) u_cls (
        .cpu_start (cpu_start),
        .ctl_start (ctl_start),
        .in_burst  (in_burst),
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .bsel_n    (bsel_n),
        .kind      (kind),
        .lane_we   (lane_we)
    );

    blw_lane_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk     (clk),
        .wr_addr (addr),
        .we      (lane_we),
        .wdata   (wr_data),
        .rd_addr (st_q.addr),
        .rdata   (rd_data)
    );

    always_comb begin
        st_d    = st_q;
        st_d.rd = (kind == CYC_READ);
        if (kind != CYC_IDLE) begin
            st_d.addr = addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // live write decode overrides the output enable
    assign drv_en = st_q.rd && !oe_n && (kind != CYC_WRITE);

    AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_start && (ctl_start || in_burst) && !gw_n) |-> lane_we == '1); // R1
    AST_BYTE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n && bwe_n) |-> lane_we == '0); // R2
    AST_CPU_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_start |-> lane_we == '0); // R3
    AST_WRITE_KILLS_DRV: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_we) |-> !drv_en); // R6
    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drv_en); // R7
    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_start && !ctl_start && !in_burst) |=> !drv_en); // R8
    AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_start && !ctl_start && !in_burst) |-> lane_we == '0); // R8
endmodule

// File: tb/blw_write_ctrl_test.sv
module blw_write_ctrl_test;
    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_start = 1'b0, ctl_start = 1'b0, in_burst = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]    bsel_n = 4'hF;
    logic          oe_n = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic          drv_en;
    logic [3:0]    lane_we;

    logic [31:0] model [NW];
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    blw_write_ctrl #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_start(cpu_start), .ctl_start(ctl_start),
        .in_burst(in_burst), .addr(addr), .gw_n(gw_n), .bwe_n(bwe_n),
        .bsel_n(bsel_n), .oe_n(oe_n), .wr_data(wr_data), .rd_data(rd_data),
        .drv_en(drv_en), .lane_we(lane_we)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic set_cyc(input logic c, input logic t, input logic b);
        cpu_start = c; ctl_start = t; in_burst = b;
    endtask

    task automatic no_write();
        gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk("watchdog", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 reset drv_en", {31'd0, drv_en}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R10 idle after reset", {31'd0, drv_en}, 32'd0);

        // fill every word with a global write from a controller start (R1, R4)
        for (int a = 0; a < NW; a++) begin
            @(negedge clk);
            set_cyc(1'b0, 1'b1, 1'b0);
            gw_n = 1'b0; bwe_n = 1'b1; bsel_n = 4'hF;
            addr = AW'(a);
            wr_data = 32'hA500_0000 ^ (32'(a) * 32'h0103_0507);
            #1;
            chk("R1 fill strobes", {28'd0, lane_we}, 32'hF);
            model[a] = wr_data;
            @(posedge clk);
        end

        // sweep: cycle kind x global write x byte enable x selects
        for (int m = 0; m < 4; m++) begin
            for (int g = 0; g < 2; g++) begin
                for (int b = 0; b < 2; b++) begin
                    for (int s = 0; s < 16; s++) begin
                        int idx;
                        int a;
                        logic [3:0] mask, expwe;
                        logic qual;
                        string tag;
                        idx = m * 64 + g * 32 + b * 16 + s;
                        a = idx % NW;

                        // prime a read with a controller start, no write
                        @(negedge clk);
                        set_cyc(1'b0, 1'b1, 1'b0);
                        no_write();
                        addr = AW'(a); oe_n = 1'b0;
                        @(posedge clk); #1;
                        chk("R7 read drv_en", {31'd0, drv_en}, 32'd1);
                        chk("R7 read data", rd_data, model[a]);

                        // stimulus cycle
                        @(negedge clk);
                        case (m)
                            0: set_cyc(1'b1, 1'b0, 1'b0);
                            1: set_cyc(1'b0, 1'b1, 1'b0);
                            2: set_cyc(1'b0, 1'b0, 1'b1);
                            default: set_cyc(1'b1, 1'b1, 1'b0);
                        endcase
                        gw_n = g[0]; bwe_n = b[0]; bsel_n = s[3:0];
                        wr_data = 32'(idx) * 32'h9E37_79B1;
                        qual = (m == 1) || (m == 2);
                        mask = (g == 0) ? 4'hF : ((b == 0) ? ~s[3:0] : 4'h0);
                        expwe = qual ? mask : 4'h0;
                        if (m == 0 || m == 3) tag = "R3 cpu start strobes";
                        else if (g == 0) tag = "R1 global strobes";
                        else if (m == 2) tag = "R5 burst byte strobes";
                        else tag = "R2 byte strobes";
                        if (m == 3) tag = "R4 ctl masked by cpu";
                        #1;
                        chk(tag, {28'd0, lane_we}, {28'd0, expwe});
                        chk("R6 drv_en during write", {31'd0, drv_en}, {31'd0, (expwe == 4'h0)});
                        for (int l = 0; l < 4; l++) begin
                            if (expwe[l]) model[a][l*8 +: 8] = wr_data[l*8 +: 8];
                        end
                        @(posedge clk); #1;
                        if (expwe != 4'h0) begin
                            chk("R6 drv_en after write", {31'd0, drv_en}, 32'd0);
                            // R9: read back merged word on the next cycle
                            @(negedge clk);
                            set_cyc(1'b0, 1'b0, 1'b1);
                            no_write();
                            @(posedge clk); #1;
                            chk("R9 merged read drv_en", {31'd0, drv_en}, 32'd1);
                            chk("R9 merged read data", rd_data, model[a]);
                        end else begin
                            chk("R3 read registered", {31'd0, drv_en}, 32'd1);
                            chk("R3 read data", rd_data, model[a]);
                        end
                    end
                end
            end
        end

        // R7: output enable acts without the clock
        @(negedge clk);
        set_cyc(1'b0, 1'b0, 1'b1);
        no_write();
        @(posedge clk); #1;
        oe_n = 1'b1; #1;
        chk("R7 oe high", {31'd0, drv_en}, 32'd0);
        oe_n = 1'b0; #0.5;
        chk("R7 oe low", {31'd0, drv_en}, 32'd1);

        // R8: idle cycle with write inputs active
        @(negedge clk);
        set_cyc(1'b0, 1'b0, 1'b0);
        gw_n = 1'b0; bwe_n = 1'b0; bsel_n = 4'h0;
        #1;
        chk("R8 idle strobes", {28'd0, lane_we}, 32'd0);
        @(posedge clk); #1;
        chk("R8 idle drv_en", {31'd0, drv_en}, 32'd0);
        @(negedge clk);
        no_write();
        @(posedge clk); #1;
        chk("R8 idle data kept", {31'd0, drv_en}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule